// File: doc/BRIEF.md
# Slot Power Limit Message Controller

This block sits beside a PCIe root port and decides when the port should send a Set_Slot_Power_Limit message to the device below it. It holds an 8-bit limit value, a 2-bit scale and a send-enable flag. When the data link goes from down to up while the send-enable is set, it raises a request toward the transaction layer. The request carries the programmed value and scale and stays up until that layer acknowledges it.

The block also gives software two configuration words. One is the slot capability word, which reports the limit and the physical slot number. The other is the combined slot control and slot status word, which carries the auto-power-limit-disable flag. While a non-zero limit is programmed, that flag is the inverse of the hardware send-enable and writing it changes the enable. While the limit is zero, the flag is a plain shadow bit and has no effect on the hardware.

Register port addresses: 0 is the limit control register, 1 is the slot capability word (read only), 2 is the slot control and status word, and a write to 3 is the teardown command. Reads are combinational on `addr`. A write takes effect at the rising clock edge that samples `wr_en` high.

Top module: `spl_msg_ctrl`

## Requirements
- R1: After reset, the control register reads 0, `msg_req` is 0 and the disable flag (bit 13 at address 2) reads 0.
- R2: A write to address 0 with a non-zero value in bits 7:0 stores that value and the scale from bits 9:8, and sets the enable (read back at bit 16). A zero value clears the value, the scale and the enable together. Bit 16 of the write data is ignored.
- R3: With the enable set, `msg_req` rises at the clock edge after the first edge that samples `link_up` high following a low sample.
- R4: `msg_req` stays high until an edge samples `msg_ack` high, and is low after that edge.
- R5: A second down-to-up link transition seen while a request is pending is merged into it. After one acknowledge, no further request follows.
- R6: With the enable clear, a down-to-up link transition raises no request.
- R7: With a non-zero value, the disable flag reads as the inverse of the enable. Writing 1 to bit 13 at address 2 clears the enable and writing 0 sets it.
- R8: With a zero value, a write to bit 13 at address 2 leaves the enable unchanged, and the flag reads back the last value written.
- R9: Bits 31:16 at address 2 hold slot status. Its bit 6 (word bit 22) always reads 1 and all other status bits read 0.
- R10: Address 1 reports the value in bits 14:7, the scale in bits 16:15 and the slot number PORT_IDX+1 in bits 31:19. All other bits read 0.
- R11: A write to address 3 clears the value, the scale and the enable.
- R12: A `link_up` pulse that no rising clock edge samples raises no request.
- R13: While `msg_req` is high, `msg_value` and `msg_scale` equal the programmed value and scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| link_up | input | 1 | Data link active status |
| msg_req | output | 1 | Request to send the power limit message |
| msg_ack | input | 1 | Transaction layer has taken the request |
| msg_value | output | 8 | Limit value carried by the message |
| msg_scale | output | 2 | Limit scale carried by the message |

## Verification
The bench checks the disable flag both ways. A design that always shadows the flag would let software write it with no effect on a live enable. A design that always routes the flag to the enable would switch messaging on for a zero limit when software writes 0. It also sends a second link-up edge while a request is pending. A design that queues edges would raise a second request after the acknowledge. A design that takes edges straight from the raw input would fire on a pulse that falls between clock edges, and the bench catches that too. The request timing is checked exactly at the expected edge. The slot number offset and the forced presence bit are checked by reading the register words.

// File: rtl/spl_pkg.sv
package spl_pkg;
    localparam int VAL_W = 8;
    localparam int SCL_W = 2;
    localparam int REG_W = 32;
    localparam int ADR_W = 2;

    localparam logic [ADR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADR_W-1:0] ADR_CAP  = 2'd1;
    localparam logic [ADR_W-1:0] ADR_SCTL = 2'd2;
    localparam logic [ADR_W-1:0] ADR_TEAR = 2'd3;

    localparam int CTRL_SCL_LSB = 8;
    localparam int CTRL_EN_BIT  = 16;
    localparam int SCTL_DIS_BIT = 13;
    localparam int STA_LSB      = 16;
    localparam int STA_PDS_BIT  = 6;
    localparam int CAP_VAL_LSB  = 7;
    localparam int CAP_SCL_LSB  = 15;
    localparam int CAP_PSN_LSB  = 19;

    typedef struct packed {
        logic [VAL_W-1:0] val;
        logic [SCL_W-1:0] scl;
        logic             en;
        logic             shadow;
    } cfg_t;
endpackage

// File: rtl/spl_link_edge.sv
module spl_link_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic up_rise
);
    typedef struct packed {
        logic link;
        logic prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.link = link_up;
        st_d.prev = st_q.link;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_rise = st_q.link & ~st_q.prev;
endmodule

// File: rtl/spl_cfg_regs.sv
module spl_cfg_regs
    import spl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [VAL_W-1:0] wr_val,
    input  logic [SCL_W-1:0] wr_scl,
    input  logic             wr_dis,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                ADR_CTRL: begin
                    cfg_d.val = wr_val;
                    if (wr_val != '0) begin
                        cfg_d.scl = wr_scl;
                        cfg_d.en  = 1'b1;
                    end else begin
                        cfg_d.scl = '0;
                        cfg_d.en  = 1'b0;
                    end
                end
                ADR_SCTL: begin
                    if (cfg_q.val != '0) cfg_d.en     = ~wr_dis;
                    else                 cfg_d.shadow = wr_dis;
                end
                ADR_TEAR: begin
                    cfg_d.val = '0;
                    cfg_d.scl = '0;
                    cfg_d.en  = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/spl_req_track.sv
module spl_req_track (
    input  logic clk,
    input  logic rst_n,
    input  logic up_rise,
    input  logic send_en,
    input  logic msg_ack,
    output logic msg_req
);
    logic req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (req_q && msg_ack) req_d = 1'b0;
        if (up_rise && send_en) req_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign msg_req = req_q;
endmodule

// File: rtl/spl_msg_ctrl.sv
module spl_msg_ctrl
    import spl_pkg::*;
#(
    parameter int PORT_IDX = 0,
    parameter int PSN_W    = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             link_up,
    output logic             msg_req,
    input  logic             msg_ack,
    output logic [VAL_W-1:0] msg_value,
    output logic [SCL_W-1:0] msg_scale
);
    localparam logic [PSN_W-1:0] SLOT_NUM = PSN_W'(PORT_IDX + 1);

    cfg_t cfg;
    logic up_rise;

    spl_link_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .link_up (link_up),
        .up_rise (up_rise)
    );

    spl_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_val (wdata[VAL_W-1:0]),
        .wr_scl (wdata[CTRL_SCL_LSB +: SCL_W]),
        .wr_dis (wdata[SCTL_DIS_BIT]),
        .cfg    (cfg)
    );

    spl_req_track u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_rise (up_rise),
        .send_en (cfg.en),
        .msg_ack (msg_ack),
        .msg_req (msg_req)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: begin
                rdata[VAL_W-1:0]             = cfg.val;
                rdata[CTRL_SCL_LSB +: SCL_W] = cfg.scl;
                rdata[CTRL_EN_BIT]           = cfg.en;
            end
            ADR_CAP: begin
                rdata[CAP_VAL_LSB +: VAL_W] = cfg.val;
                rdata[CAP_SCL_LSB +: SCL_W] = cfg.scl;
                rdata[CAP_PSN_LSB +: PSN_W] = SLOT_NUM;
            end
            ADR_SCTL: begin
                rdata[SCTL_DIS_BIT]          = (cfg.val != '0) ? ~cfg.en : cfg.shadow;
                rdata[STA_LSB + STA_PDS_BIT] = 1'b1;
            end
            default: ;
        endcase
    end

    assign msg_value = cfg.val;
    assign msg_scale = cfg.scl;
endmodule

// File: rtl/spl_msg_ctrl_chk.sv
module spl_msg_ctrl_chk
    import spl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [ADR_W-1:0] addr,
    input logic [REG_W-1:0] rdata,
    input logic             link_up,
    input logic             msg_req,
    input logic             msg_ack,
    input logic             send_en,
    input logic [VAL_W-1:0] cur_val
);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_ack) |=> msg_req);

    p_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(msg_req) |-> $past(msg_ack));

    p_req_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_req) |-> $past(send_en));

    p_req_after_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_req) |-> $past(link_up));

    p_teardown_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_TEAR) |=> (cur_val == '0 && !send_en));

    p_pds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADR_SCTL) |-> rdata[STA_LSB + STA_PDS_BIT]);
endmodule

bind spl_msg_ctrl spl_msg_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .link_up (link_up),
    .msg_req (msg_req),
    .msg_ack (msg_ack),
    .send_en (cfg.en),
    .cur_val (cfg.val)
);

// File: tb/spl_msg_ctrl_tb.sv
module spl_msg_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        link_up = 1'b0;
    logic        msg_req;
    logic        msg_ack = 1'b0;
    logic [7:0]  msg_value;
    logic [1:0]  msg_scale;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spl_msg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .link_up(link_up), .msg_req(msg_req), .msg_ack(msg_ack),
        .msg_value(msg_value), .msg_scale(msg_scale)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic link_down();
        link_up = 1'b0;
        cyc(3);
    endtask

    task automatic do_ack();
        msg_ack = 1'b1;
        cyc(1);
        msg_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R1 ctrl", d, 32'h0);
        rd(2'd2, d); check("R1 flag", {31'b0, d[13]}, 32'h0);
        check("R1 req", {31'b0, msg_req}, 32'h0);
    endtask

    task automatic t_ctrl_load();
        logic [31:0] d;
        wr(2'd0, 32'h0000_0312);
        rd(2'd0, d); check("R2 nonzero load", d, 32'h0001_0312);
        wr(2'd0, 32'h0001_0300);
        rd(2'd0, d); check("R2 zero load", d, 32'h0);
    endtask

    task automatic t_msg_basic();
        wr(2'd0, 32'h0000_0125);
        @(negedge clk); link_up = 1'b1;
        cyc(1); check("R3 not early", {31'b0, msg_req}, 32'h0);
        cyc(1); check("R3 raised", {31'b0, msg_req}, 32'h1);
        check("R13 value", {24'b0, msg_value}, 32'h25);
        check("R13 scale", {30'b0, msg_scale}, 32'h1);
        cyc(4); check("R4 held", {31'b0, msg_req}, 32'h1);
        do_ack(); check("R4 cleared", {31'b0, msg_req}, 32'h0);
        link_down();
    endtask

    task automatic t_merge();
        link_up = 1'b1; cyc(2);
        check("R5 first req", {31'b0, msg_req}, 32'h1);
        link_up = 1'b0; cyc(2);
        link_up = 1'b1; cyc(3);
        check("R5 still pending", {31'b0, msg_req}, 32'h1);
        do_ack(); cyc(3);
        check("R5 no second req", {31'b0, msg_req}, 32'h0);
        link_down();
    endtask

    task automatic t_disabled();
        wr(2'd3, 32'h0);
        link_up = 1'b1; cyc(4);
        check("R6 no req", {31'b0, msg_req}, 32'h0);
        link_down();
    endtask

    task automatic t_glitch();
        wr(2'd0, 32'h0000_0010);
        @(negedge clk);
        link_up = 1'b1; #2; link_up = 1'b0;
        cyc(4);
        check("R12 glitch ignored", {31'b0, msg_req}, 32'h0);
    endtask

    task automatic t_flag_nonzero();
        logic [31:0] d;
        wr(2'd0, 32'h0000_0140);
        rd(2'd2, d); check("R7 flag reads ~en", {31'b0, d[13]}, 32'h0);
        wr(2'd2, 32'h0000_2000);
        rd(2'd0, d); check("R7 enable cleared", {31'b0, d[16]}, 32'h0);
        rd(2'd2, d); check("R7 flag set", {31'b0, d[13]}, 32'h1);
        link_up = 1'b1; cyc(4);
        check("R7 no msg when disabled", {31'b0, msg_req}, 32'h0);
        link_down();
        wr(2'd2, 32'h0);
        rd(2'd0, d); check("R7 enable set", {31'b0, d[16]}, 32'h1);
        rd(2'd2, d); check("R7 flag clear", {31'b0, d[13]}, 32'h0);
    endtask

    task automatic t_flag_zero();
        logic [31:0] d;
        wr(2'd3, 32'h0);
        wr(2'd2, 32'h0000_2000);
        rd(2'd2, d); check("R8 shadow 1", {31'b0, d[13]}, 32'h1);
        rd(2'd0, d); check("R8 ctrl untouched", d, 32'h0);
        wr(2'd2, 32'h0);
        rd(2'd2, d); check("R8 shadow 0", {31'b0, d[13]}, 32'h0);
        rd(2'd0, d); check("R8 enable stays off", d, 32'h0);
        link_up = 1'b1; cyc(4);
        check("R8 no msg", {31'b0, msg_req}, 32'h0);
        link_down();
    endtask

    task automatic t_status();
        logic [31:0] d;
        rd(2'd2, d); check("R9 status half", {16'b0, d[31:16]}, 32'h0040);
    endtask

    task automatic t_cap();
        logic [31:0] d;
        wr(2'd0, 32'h0000_025A);
        rd(2'd1, d);
        check("R10 cap word", d, (32'd1 << 19) | (32'd2 << 15) | (32'h5A << 7));
    endtask

    task automatic t_teardown();
        logic [31:0] d;
        wr(2'd0, 32'h0000_03FF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R11 teardown", d, 32'h0);
        rd(2'd1, d); check("R11 cap after teardown", d, 32'd1 << 19);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_ctrl_load();
        t_msg_basic();
        t_merge();
        t_disabled();
        t_glitch();
        t_flag_nonzero();
        t_flag_zero();
        t_status();
        t_cap();
        t_teardown();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule